// File: doc/BRIEF.md
# Run-Time Configurable Binary Extension Field Multiplier

This block multiplies two elements of a binary extension field GF(2^m). Both the degree m and the reducing polynomial arrive with each operation, so one instance serves every field size from GF(2) up to a fixed maximum width `W`. The polynomial is plain data. Its low m bits give the coefficients below x^m, and the leading x^m term is implied. The arithmetic works the same way for any polynomial, so nothing about a specific field is built into the hardware.

A small alignment front end runs first. It masks the operands and the polynomial down to the low m bits. It also builds a field mask and a one-hot marker that shows where the top coefficient sits, so a field of any size uses the same full-width array. The array reads the multiplier LSB first. Each row does two things:

- It XORs the current multiple of A into an accumulator when the multiplier bit is set.
- It then multiplies that multiple by x, reduced by the polynomial.

The rows are split into four equal groups, with a register bank after each group. One operation is accepted every clock, and any mix of degrees and polynomials can follow each other cycle by cycle.

Top module: `gf_mult`

## Requirements
- R1: When `vld_o` is high, `prod_o` equals A·B reduced modulo P(x) = x^m + `poly_i[m-1:0]`, where bit 0 of each input is the constant coefficient.
- R2: The degree `m_i` is read on every operation. The value 1 gives GF(2), which is a bitwise AND of bit 0. Any value above `W` behaves as `W`. The value 0 yields a zero product.
- R3: Bits of `a_i`, `b_i` and `poly_i` at position m or above have no effect on the result. Bits of `prod_o` at position m or above are always 0.
- R4: Inputs sampled at rising edge n appear on `vld_o`/`prod_o` right after rising edge n+3. `vld_o` is `vld_i` delayed by exactly that amount.
- R5: A new operation can be issued on every clock. Back-to-back operations may each use a different degree and polynomial without affecting one another.
- R6: While `rst_ni` is low, `vld_o` and `prod_o` are 0.
- R7: When B = 1, the product equals A masked to its low m bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| vld_i | input | 1 | Operation present on the inputs |
| m_i | input | $clog2(W+1) | Field degree m |
| poly_i | input | W | Reducing polynomial without its x^m term, bit 0 = constant |
| a_i | input | W | Multiplicand A |
| b_i | input | W | Multiplier B, consumed LSB first |
| vld_o | output | 1 | Product present on `prod_o` |
| prod_o | output | W | Reduced product, zero above bit m-1 |

## Verification
The embedded properties assume the following about the inputs:

- `m_i` is never unknown out of reset, so the alignment marker is one-hot, or empty exactly when m is 0.
- `vld_i` is driven to a known level on every clock, so the delayed shadow of it matches the output valid.

The stimulus meets these assumptions. It drives every input from the first instant and changes inputs only on falling edges. Even on idle cycles it puts full-width random data on the operands and the polynomial, which exercises the masking without ever leaving the degree unknown. Degrees range over 0, 1, several mid sizes, the maximum, and values above the maximum.

// File: rtl/gfm_pkg.sv
package gfm_pkg;

    // number of register banks the multiplier array is cut into
    localparam int unsigned GFM_STAGES = 4;

    // multiplier bits consumed by each bank
    function automatic int unsigned gfm_rows_per_stage(input int unsigned width);
        return (width + GFM_STAGES - 1) / GFM_STAGES;
    endfunction

    // rows actually present in bank s (last bank may be short)
    function automatic int unsigned gfm_rows_in_stage(input int unsigned width,
                                                      input int unsigned s);
        int unsigned first;
        int unsigned per;
        per   = gfm_rows_per_stage(width);
        first = s * per;
        if (first >= width)       return 0;
        if (width - first < per)  return width - first;
        return per;
    endfunction

endpackage

// File: rtl/gfm_field_align.sv
// Maps a field of degree m onto the full-width array: masks the
// operands and polynomial, and marks the top coefficient position.
module gfm_field_align #(
    parameter int unsigned W  = 32,
    parameter int unsigned MW = $clog2(W + 1)
) (
    input  logic [MW-1:0] m_i,
    input  logic [W-1:0]  a_i,
    input  logic [W-1:0]  b_i,
    input  logic [W-1:0]  poly_i,
    output logic [W-1:0]  a_o,
    output logic [W-1:0]  b_o,
    output logic [W-1:0]  poly_o,
    output logic [W-1:0]  mask_o,
    output logic [W-1:0]  top_o
);

    logic [W-1:0] mask;
    logic [W-1:0] top;

    for (genvar i = 0; i < W; i++) begin : g_bit
        // coefficient i lies inside the field when i < m
        assign mask[i] = (m_i > MW'(i));
        if (i == W - 1) begin : g_last
            // degrees beyond the array act as the full width
            assign top[i] = (m_i >= MW'(W));
        end else begin : g_mid
            assign top[i] = (m_i == MW'(i + 1));
        end
    end

    assign mask_o = mask;
    assign top_o  = top;
    assign a_o    = a_i & mask;
    assign b_o    = b_i & mask;
    assign poly_o = poly_i & mask;

endmodule

// File: rtl/gfm_row.sv
// One cell row: conditional accumulate, then multiply A by x mod P.
module gfm_row #(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] acc_i,
    input  logic [W-1:0] a_i,
    input  logic         bit_i,
    input  logic [W-1:0] poly_i,
    input  logic [W-1:0] mask_i,
    input  logic [W-1:0] top_i,
    output logic [W-1:0] acc_o,
    output logic [W-1:0] a_o
);

    logic         carry;
    logic [W-1:0] shifted;

    always_comb begin
        acc_o   = acc_i ^ (a_i & {W{bit_i}});
        carry   = |(a_i & top_i);
        shifted = {a_i[W-2:0], 1'b0} & mask_i;
        a_o     = shifted ^ (poly_i & {W{carry}});
    end

endmodule

// File: rtl/gfm_stage.sv
// A group of consecutive array rows followed by one register bank.
module gfm_stage #(
    parameter int unsigned W     = 32,
    parameter int unsigned ROW0  = 0,
    parameter int unsigned NROWS = 8
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         vld_i,
    input  logic [W-1:0] acc_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic [W-1:0] poly_i,
    input  logic [W-1:0] mask_i,
    input  logic [W-1:0] top_i,
    output logic         vld_o,
    output logic [W-1:0] acc_o,
    output logic [W-1:0] a_o,
    output logic [W-1:0] b_o,
    output logic [W-1:0] poly_o,
    output logic [W-1:0] mask_o,
    output logic [W-1:0] top_o
);

    typedef struct packed {
        logic         vld;
        logic [W-1:0] acc;
        logic [W-1:0] a;
        logic [W-1:0] b;
        logic [W-1:0] poly;
        logic [W-1:0] mask;
        logic [W-1:0] top;
    } stg_t;

    stg_t st_d;
    stg_t st_q;

    logic [NROWS:0][W-1:0] acc_c;
    logic [NROWS:0][W-1:0] a_c;

    assign acc_c[0] = acc_i;
    assign a_c[0]   = a_i;

    for (genvar r = 0; r < NROWS; r++) begin : g_row
        gfm_row #(.W(W)) i_row (
            .acc_i  (acc_c[r]),
            .a_i    (a_c[r]),
            .bit_i  (b_i[ROW0 + r]),
            .poly_i (poly_i),
            .mask_i (mask_i),
            .top_i  (top_i),
            .acc_o  (acc_c[r + 1]),
            .a_o    (a_c[r + 1])
        );
    end

    always_comb begin
        st_d      = st_q;
        st_d.vld  = vld_i;
        st_d.acc  = acc_c[NROWS];
        st_d.a    = a_c[NROWS];
        st_d.b    = b_i;
        st_d.poly = poly_i;
        st_d.mask = mask_i;
        st_d.top  = top_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign vld_o  = st_q.vld;
    assign acc_o  = st_q.acc;
    assign a_o    = st_q.a;
    assign b_o    = st_q.b;
    assign poly_o = st_q.poly;
    assign mask_o = st_q.mask;
    assign top_o  = st_q.top;

    // the running multiple and partial sum never leave the field (R3)
    assert_field_kept_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.vld |-> (((st_q.a | st_q.acc) & ~st_q.mask) == '0));

endmodule

// File: rtl/gf_mult.sv
module gf_mult
    import gfm_pkg::*;
#(
    parameter  int unsigned W  = 32,
    localparam int unsigned MW = $clog2(W + 1)
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          vld_i,
    input  logic [MW-1:0] m_i,
    input  logic [W-1:0]  poly_i,
    input  logic [W-1:0]  a_i,
    input  logic [W-1:0]  b_i,
    output logic          vld_o,
    output logic [W-1:0]  prod_o
);

    localparam int unsigned RPS = gfm_rows_per_stage(W);

    logic [W-1:0] al_a, al_b, al_poly, al_mask, al_top;

    logic [GFM_STAGES:0]        s_vld;
    logic [GFM_STAGES:0][W-1:0] s_acc, s_a, s_b, s_poly, s_mask, s_top;

    gfm_field_align #(.W(W), .MW(MW)) i_align (
        .m_i    (m_i),
        .a_i    (a_i),
        .b_i    (b_i),
        .poly_i (poly_i),
        .a_o    (al_a),
        .b_o    (al_b),
        .poly_o (al_poly),
        .mask_o (al_mask),
        .top_o  (al_top)
    );

    assign s_vld[0]  = vld_i;
    assign s_acc[0]  = '0;
    assign s_a[0]    = al_a;
    assign s_b[0]    = al_b;
    assign s_poly[0] = al_poly;
    assign s_mask[0] = al_mask;
    assign s_top[0]  = al_top;

    for (genvar s = 0; s < GFM_STAGES; s++) begin : g_stage
        localparam int unsigned R0 = s * RPS;
        localparam int unsigned NR = gfm_rows_in_stage(W, s);
        gfm_stage #(.W(W), .ROW0(R0), .NROWS(NR)) i_stage (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .vld_i  (s_vld[s]),
            .acc_i  (s_acc[s]),
            .a_i    (s_a[s]),
            .b_i    (s_b[s]),
            .poly_i (s_poly[s]),
            .mask_i (s_mask[s]),
            .top_i  (s_top[s]),
            .vld_o  (s_vld[s + 1]),
            .acc_o  (s_acc[s + 1]),
            .a_o    (s_a[s + 1]),
            .b_o    (s_b[s + 1]),
            .poly_o (s_poly[s + 1]),
            .mask_o (s_mask[s + 1]),
            .top_o  (s_top[s + 1])
        );
    end

    assign vld_o  = s_vld[GFM_STAGES];
    assign prod_o = s_acc[GFM_STAGES];

    // control that has finished its trip through the array
    logic unused_tail;
    assign unused_tail = ^{s_a[GFM_STAGES], s_b[GFM_STAGES],
                           s_poly[GFM_STAGES], s_top[GFM_STAGES]};

    // ---------------- checks ----------------
    logic [GFM_STAGES-1:0] vhist_d, vhist_q;

    always_comb begin
        vhist_d = {vhist_q[GFM_STAGES-2:0], vld_i};
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            vhist_q <= '0;
        end else begin
            vhist_q <= vhist_d;
        end
    end

    assert_valid_latency_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        vld_o == vhist_q[GFM_STAGES-1]);

    assert_upper_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        vld_o |-> ((prod_o & ~s_mask[GFM_STAGES]) == '0));

    assert_degree_select_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(al_top) && ((al_top == '0) == (m_i == '0)));

endmodule

// File: tb/test_gf_mult.sv
`timescale 1ns/1ps
module test_gf_mult;

    localparam int unsigned W  = 32;
    localparam int unsigned MW = $clog2(W + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          vld_i = 1'b0;
    logic [MW-1:0] m_i = '0;
    logic [W-1:0]  poly_i = '0;
    logic [W-1:0]  a_i = '0;
    logic [W-1:0]  b_i = '0;
    logic          vld_o;
    logic [W-1:0]  prod_o;

    always #4 clk = ~clk;

    gf_mult #(.W(W)) i_gf_mult (
        .clk_i  (clk),
        .rst_ni (rst_n),
        .vld_i  (vld_i),
        .m_i    (m_i),
        .poly_i (poly_i),
        .a_i    (a_i),
        .b_i    (b_i),
        .vld_o  (vld_o),
        .prod_o (prod_o)
    );

    typedef struct {
        logic         vld;
        logic [W-1:0] exp;
        string        tag;
    } ent_t;

    ent_t pipe[$];
    ent_t cur = '{1'b0, '0, "R4"};
    int   checks = 0;
    int   errors = 0;
    bit   done = 0;

    // bit-serial, MSB-first reference (Horner form)
    function automatic logic [W-1:0] ref_mul(input logic [W-1:0] a, input logic [W-1:0] b,
                                             input logic [W-1:0] p, input int m_in);
        int           m;
        logic [W-1:0] msk;
        logic [W-1:0] r;
        logic         hi;
        m = (m_in > W) ? W : m_in;
        if (m == 0) return '0;
        msk = W'((64'd1 << m) - 64'd1);
        a &= msk; b &= msk; p &= msk;
        r = '0;
        for (int i = m - 1; i >= 0; i--) begin
            hi = r[m-1];
            r  = (r << 1) & msk;
            if (hi)   r ^= p;
            if (b[i]) r ^= a;
        end
        return r;
    endfunction

    // cycle model of the pipeline: newest at front
    always @(posedge clk) begin
        if (!rst_n) begin
            pipe.delete();
        end else begin
            pipe.push_front(cur);
            if (pipe.size() > 4) void'(pipe.pop_back());
        end
    end

    task automatic compare();
        logic         ev;
        logic [W-1:0] ex;
        string        tg;
        ev = 1'b0; ex = '0; tg = "R4";
        if (pipe.size() == 4) begin
            ev = pipe[3].vld; ex = pipe[3].exp; tg = pipe[3].tag;
        end
        checks++;
        if (vld_o !== ev) begin
            errors++;
            $display("FAIL R4 vld_o actual %b expected %b at %0t", vld_o, ev, $time);
        end
        if (ev) begin
            checks++;
            if (prod_o !== ex) begin
                errors++;
                $display("FAIL %s prod_o actual %h expected %h at %0t", tg, prod_o, ex, $time);
            end
        end
    endtask

    task automatic op(input logic v, input int m, input logic [W-1:0] p,
                      input logic [W-1:0] a, input logic [W-1:0] b,
                      input string tag, input bit known, input logic [W-1:0] kval);
        @(negedge clk);
        compare();
        vld_i  = v;
        m_i    = MW'(m);
        poly_i = p;
        a_i    = a;
        b_i    = b;
        cur.vld = v;
        cur.tag = tag;
        cur.exp = known ? kval : ref_mul(a, b, p, m);
    endtask

    function automatic logic [W-1:0] rnd();
        return W'($urandom());
    endfunction

    // standard primitive polynomials, x^m term implied
    task automatic pick_field(input int idx, output int m, output logic [W-1:0] p);
        case (idx)
            0: begin m = 4;  p = 32'h3;        end
            1: begin m = 5;  p = 32'h5;        end
            2: begin m = 7;  p = 32'h3;        end
            3: begin m = 8;  p = 32'h1D;       end
            4: begin m = 13; p = 32'h1B;       end
            5: begin m = 16; p = 32'h100B;     end
            default: begin m = 32; p = 32'h00400007; end
        endcase
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL R4 watchdog actual hung expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int           m;
        logic [W-1:0] p;
        logic [W-1:0] a;

        // R6: outputs held clear in reset even with activity on inputs
        vld_i = 1'b1; m_i = MW'(8); a_i = '1; b_i = '1; poly_i = 32'h1D;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            checks++;
            if (vld_o !== 1'b0 || prod_o !== '0) begin
                errors++;
                $display("FAIL R6 reset actual %b/%h expected 0/0", vld_o, prod_o);
            end
        end
        vld_i = 1'b0;
        rst_n = 1'b1;

        // R1: known field products
        op(1, 8, 32'h1B, 32'h53, 32'hCA, "R1", 1, 32'h01);
        op(1, 8, 32'h1D, 32'h02, 32'h80, "R1", 1, 32'h1D);
        op(1, 4, 32'h3,  32'h8,  32'h2,  "R1", 1, 32'h3);
        // R2: GF(2), degree zero and degree beyond the array
        op(1, 1, 32'h1, 32'h1, 32'h1, "R2", 1, 32'h1);
        op(1, 1, 32'h1, 32'hFFFF_FFFF, 32'hFFFF_FFFE, "R2", 1, 32'h0);
        op(1, 0, 32'h1D, rnd(), rnd(), "R2", 1, 32'h0);
        for (int k = 0; k < 10; k++) begin
            a = rnd();
            p = rnd();
            op(1, 63, 32'h00400007, a, p, "R2", 1, ref_mul(a, p, 32'h00400007, 32));
        end
        // R7: multiply by one gives back A within the field
        for (int k = 0; k < 10; k++) begin
            a = rnd();
            op(1, 16, 32'h100B, a, 32'h1 | (rnd() & 32'hFFFF_0000), "R7", 1, a & 32'h0000_FFFF);
        end
        // R3: junk above bit m on every data input, including bit m of poly
        for (int k = 0; k < 20; k++) begin
            op(1, 8, (rnd() & 32'hFFFF_FF00) | 32'h1D, rnd(), rnd(), "R3", 0, '0);
        end
        // R5: back-to-back operations with changing degree and polynomial
        for (int k = 0; k < 300; k++) begin
            pick_field(int'($urandom_range(0, 6)), m, p);
            op(1, m, p, rnd(), rnd(), "R5", 0, '0);
        end
        // R1: maximum width alone
        for (int k = 0; k < 40; k++) begin
            op(1, 32, 32'h00400007, rnd(), rnd(), "R1", 0, '0);
        end
        // R4: gaps in the valid stream, random data on idle cycles
        for (int k = 0; k < 200; k++) begin
            pick_field(int'($urandom_range(0, 6)), m, p);
            op(logic'($urandom_range(0, 1)), m, p, rnd(), rnd(), "R4", 0, '0);
        end
        // drain
        for (int k = 0; k < 6; k++) begin
            op(0, 8, 32'h1D, rnd(), rnd(), "R4", 0, '0);
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule